// File: doc/BRIEF.md
# Serial EEPROM Target Protocol Engine

This block is the target-side transaction engine of a two-wire serial EEPROM. A front end, outside this block, recovers bus conditions and hands over one-cycle strobes: a start condition, a stop condition, a completed received byte (with its value), and a request for the next outgoing read byte. From these the engine decides whether the device is being addressed, collects a two-byte word address, gathers written bytes into a page buffer, and answers each received byte with an acknowledge level that the pad logic puts on the data line.

A stop condition that ends a write holding at least one data byte starts a self-timed write cycle. It lasts a fixed number of clock cycles, and during it the buffered bytes are copied into the storage array. For that whole time the device refuses every bus event, so a host finds out that the write has finished by sending the device address again and again until it gets an acknowledge. Reads return the byte at the current word address, and each read request moves the address on by one.

Top module: `serial_eeprom_target`

## Requirements
- R1: A byte received right after a start is acknowledged (ack high from the cycle after its strobe) only when bits 7:4 equal 4'b1010 and bits 3:1 equal `chip_sel`. On a mismatch ack stays low, and every byte is ignored (ack low) until the next start.
- R2: Bit 0 of a matching device byte selects the direction: 0 starts a write, and 1 starts a read. In a write, the next two bytes are acknowledged and form the word address. Bit 0 of the first of them is address bit 8, and the second gives address bits 7:0.
- R3: Every data byte of a write is acknowledged and lands at the current column of its page, a page being 2^PAGE_W bytes (8 by default). The column then advances and wraps inside the page, so later bytes overwrite earlier ones while the page row stays fixed.
- R4: A stop after at least one stored data byte raises `busy` in the cycle after the stop. `busy` stays high for exactly TWR cycles (40 by default), after which the written bytes can be read back.
- R5: While `busy` is high, every start, stop and byte event is ignored and ack stays low. Once `busy` has fallen, a start followed by the matching device byte is acknowledged again.
- R6: A stop with no data byte after the word address (including a stop after a read) leaves `busy` low and the storage unchanged.
- R7: While `wr_protect` is high, data bytes are still acknowledged but are not stored, and the closing stop does not raise `busy`. The earlier contents read back unchanged.
- R8: After a matching read byte, `rd_data` shows the byte at the current word address within two cycles. Each `ev_tx_next` advances the address by one, wrapping from the last storage location to location 0, and the new byte appears two cycles after the strobe.
- R9: During and right after reset, `ack` and `busy` are low and the engine waits for a start.
- R10: A start or a stop drives ack low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_sel | input | 3 | Hardwired select value compared with device-byte bits 3:1 |
| wr_protect | input | 1 | High blocks storing of written data and the write cycle |
| ev_start | input | 1 | One-cycle strobe: start or repeated start seen |
| ev_stop | input | 1 | One-cycle strobe: stop seen |
| ev_byte | input | 1 | One-cycle strobe: a byte was received into `rx_byte` |
| rx_byte | input | 8 | Value of the received byte, valid with `ev_byte` |
| ev_tx_next | input | 1 | One-cycle strobe: host took the read byte and wants the next |
| ack | output | 1 | High: drive acknowledge (low) on the data line for the last byte |
| busy | output | 1 | Self-timed write cycle in progress |
| rd_data | output | 8 | Byte to shift out during a read |

## Verification
A wrong protocol phase shows up at `ack` one cycle after the byte that exposes it, so the bench's per-clock model comparison catches a lost or extra phase at the very next byte. A wrong write-cycle counter shows up as a `busy` edge one cycle off. A wrong page column, a bad wrap or a slot that was never committed stays invisible until a later read, where `rd_data` differs two cycles after the address reaches that location. This is why every write is read back in full.

// File: rtl/eet_pkg.sv
package eet_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } eet_phase_e;

  localparam logic [3:0] EET_DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eet_rst_sync.sv
module eet_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/eet_page_buf.sv
module eet_page_buf #(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [PAGE_W-1:0] wcol,
  input  logic [7:0]        wdata,
  input  logic [PAGE_W-1:0] rcol,
  output logic [7:0]        rdata,
  output logic              rvalid
);
  localparam int PAGE = 1 << PAGE_W;

  logic [PAGE-1:0] valid_q, valid_d;
  logic [7:0]      slot_q [PAGE];

  always_comb begin
    valid_d = valid_q;
    if (clr)     valid_d = '0;
    else if (we) valid_d[wcol] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (wcol == PAGE_W'(g))) slot_q[g] <= wdata;
    end
  end

  assign rdata  = slot_q[rcol];
  assign rvalid = valid_q[rcol];
endmodule

// File: rtl/eet_wr_timer.sv
module eet_wr_timer #(
  parameter int TWR = 40,
  parameter int CW  = $clog2(TWR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          busy,
  output logic [CW-1:0] idx
);
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (go && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(TWR - 1)) busy_d = 1'b0;
      else                       cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign idx  = cnt_q;
endmodule

// File: rtl/eet_store.sv
module eet_store #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
  import eet_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 3,
  parameter int TWR    = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] chip_sel,
  input  logic       wr_protect,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_byte,
  input  logic [7:0] rx_byte,
  input  logic       ev_tx_next,
  output logic       ack,
  output logic       busy,
  output logic [7:0] rd_data
);
  localparam int PAGE = 1 << PAGE_W;
  localparam int HI_W = ADDR_W - 8;
  localparam int CW   = $clog2(TWR);

  logic              srst_n;
  eet_phase_e        ph_q, ph_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic              ack_q, ack_d;
  logic              have_q, have_d;
  logic              buf_clr, buf_we, wc_go;
  logic              wc_busy;
  logic [CW-1:0]     wc_idx;
  logic [PAGE_W-1:0] slot_sel;
  logic [7:0]        slot_data;
  logic              slot_valid;
  logic              commit_we;
  logic [ADDR_W-1:0] commit_addr;
  logic              dev_hit;
  logic [PAGE_W-1:0] col;

  eet_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  assign dev_hit = (rx_byte[7:4] == EET_DEV_TYPE) && (rx_byte[3:1] == chip_sel);
  assign col     = wa_q[PAGE_W-1:0];

  always_comb begin
    ph_d    = ph_q;
    wa_d    = wa_q;
    ack_d   = ack_q;
    have_d  = have_q;
    buf_clr = 1'b0;
    buf_we  = 1'b0;
    wc_go   = 1'b0;
    if (!wc_busy) begin
      if (ev_stop) begin
        ph_d  = ST_IDLE;
        ack_d = 1'b0;
        if ((ph_q == ST_WDAT) && have_q && !wr_protect) wc_go = 1'b1;
      end else if (ev_start) begin
        ph_d   = ST_DEV;
        ack_d  = 1'b0;
        have_d = 1'b0;
      end else if (ev_byte) begin
        ack_d = 1'b0;
        case (ph_q)
          ST_DEV: begin
            if (dev_hit) begin
              ack_d = 1'b1;
              ph_d  = rx_byte[0] ? ST_RDAT : ST_AHI;
            end else begin
              ph_d = ST_IDLE;
            end
          end
          ST_AHI: begin
            ack_d            = 1'b1;
            wa_d[ADDR_W-1:8] = rx_byte[HI_W-1:0];
            ph_d             = ST_ALO;
          end
          ST_ALO: begin
            ack_d     = 1'b1;
            wa_d[7:0] = rx_byte;
            buf_clr   = 1'b1;
            ph_d      = ST_WDAT;
          end
          ST_WDAT: begin
            ack_d = 1'b1;
            if (!wr_protect) begin
              buf_we = 1'b1;
              have_d = 1'b1;
            end
            wa_d[PAGE_W-1:0] = col + 1'b1;
          end
          default: ;
        endcase
      end else if (ev_tx_next && (ph_q == ST_RDAT)) begin
        wa_d = wa_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ph_q   <= ST_IDLE;
      wa_q   <= '0;
      ack_q  <= 1'b0;
      have_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      wa_q   <= wa_d;
      ack_q  <= ack_d;
      have_q <= have_d;
    end
  end

  eet_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (buf_clr),
    .we    (buf_we),
    .wcol  (col),
    .wdata (rx_byte),
    .rcol  (slot_sel),
    .rdata (slot_data),
    .rvalid(slot_valid)
  );

  eet_wr_timer #(.TWR(TWR), .CW(CW)) u_tmr (
    .clk  (clk),
    .rst_n(srst_n),
    .go   (wc_go),
    .busy (wc_busy),
    .idx  (wc_idx)
  );

  assign slot_sel    = wc_idx[PAGE_W-1:0];
  assign commit_we   = wc_busy && ({1'b0, wc_idx} < (CW + 1)'(PAGE)) && slot_valid;
  assign commit_addr = {wa_q[ADDR_W-1:PAGE_W], slot_sel};

  eet_store #(.AW(ADDR_W)) u_mem (
    .clk  (clk),
    .we   (commit_we),
    .waddr(commit_addr),
    .wdata(slot_data),
    .raddr(wa_q),
    .rdata(rd_data)
  );

  assign ack  = ack_q;
  assign busy = wc_busy;
endmodule

// File: rtl/eet_checker.sv
module eet_checker #(
  parameter int TWR = 40
) (
  input logic clk,
  input logic rst_n,
  input logic ev_start,
  input logic ev_stop,
  input logic ev_byte,
  input logic wr_protect,
  input logic ack,
  input logic busy
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  p_ack_after_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(ev_byte));

  p_busy_from_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ev_stop));

  p_busy_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < TWR));

  p_busy_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == TWR));

  p_no_ack_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ack);

  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wr_protect));

  p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !ack);

  p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !ack);
endmodule

bind serial_eeprom_target eet_checker #(.TWR(TWR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_start  (ev_start),
  .ev_stop   (ev_stop),
  .ev_byte   (ev_byte),
  .wr_protect(wr_protect),
  .ack       (ack),
  .busy      (busy)
);

// File: tb/serial_eeprom_target_test.sv
module serial_eeprom_target_test;
  localparam int AW   = 9;
  localparam int PW   = 3;
  localparam int TW   = 40;
  localparam int MEMN = 1 << AW;
  localparam logic [2:0] CS   = 3'b101;
  localparam logic [7:0] DEVW = 8'hAA;
  localparam logic [7:0] DEVR = 8'hAB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] chip_sel = CS;
  logic       wr_protect = 1'b0;
  logic       ev_start = 1'b0, ev_stop = 1'b0, ev_byte = 1'b0, ev_tx_next = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       ack, busy;
  logic [7:0] rd_data;

  always #10 clk = ~clk;

  serial_eeprom_target #(.ADDR_W(AW), .PAGE_W(PW), .TWR(TW)) uut (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .wr_protect(wr_protect),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte(ev_byte), .rx_byte(rx_byte),
    .ev_tx_next(ev_tx_next), .ack(ack), .busy(busy), .rd_data(rd_data)
  );

  int    checks = 0, fails = 0;
  string req = "R9";
  bit    live = 0, done = 0;

  // behavioural reference: phase 0 idle,1 device,2 addr hi,3 addr lo,4 data,5 read
  logic [7:0] mmem [MEMN];
  logic [7:0] mbuf [8];
  bit         mbv  [8];
  int         mph = 0, maddr = 0, mrem = 0;
  bit         mack = 0, mhave = 0, mbusy;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; mack = 0; mrem = 0; mhave = 0;
    end else begin
      mbusy = (mrem > 0);
      if (mrem > 0) mrem--;
      if (!mbusy) begin
        if (ev_stop) begin
          mack = 0;
          if (mph == 4 && mhave && !wr_protect) begin
            for (int i = 0; i < 8; i++)
              if (mbv[i]) mmem[(maddr & ~7) | i] = mbuf[i];
            mrem = TW;
          end
          mph = 0;
        end else if (ev_start) begin
          mph = 1; mack = 0; mhave = 0;
        end else if (ev_byte) begin
          mack = 0;
          if (mph == 1) begin
            if (rx_byte[7:4] == 4'hA && rx_byte[3:1] == chip_sel) begin
              mack = 1; mph = rx_byte[0] ? 5 : 2;
            end else mph = 0;
          end else if (mph == 2) begin
            mack = 1; maddr = (rx_byte[0] * 256) + (maddr % 256); mph = 3;
          end else if (mph == 3) begin
            mack = 1; maddr = (maddr / 256) * 256 + rx_byte; mph = 4;
            for (int i = 0; i < 8; i++) mbv[i] = 0;
          end else if (mph == 4) begin
            mack = 1;
            if (!wr_protect) begin
              mbuf[maddr % 8] = rx_byte; mbv[maddr % 8] = 1; mhave = 1;
            end
            maddr = (maddr & ~7) | ((maddr + 1) % 8);
          end
        end else if (ev_tx_next && mph == 5) begin
          maddr = (maddr + 1) % MEMN;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      chk({req, " ack"}, {31'd0, ack}, {31'd0, mack});
      chk({req, " busy"}, {31'd0, busy}, {31'd0, (mrem > 0)});
    end
  end

  task automatic pulse(int kind, logic [7:0] b);
    @(negedge clk);
    case (kind)
      0: ev_start = 1'b1;
      1: ev_stop = 1'b1;
      2: begin rx_byte = b; ev_byte = 1'b1; end
      default: ev_tx_next = 1'b1;
    endcase
    @(negedge clk);
    ev_start = 1'b0; ev_stop = 1'b0; ev_byte = 1'b0; ev_tx_next = 1'b0;
  endtask

  task automatic set_addr(int a);
    pulse(0, 8'h00); pulse(2, DEVW);
    pulse(2, 8'(a / 256)); pulse(2, 8'(a % 256));
  endtask

  task automatic write_seq(int a, int n, logic [7:0] base, bit do_stop);
    set_addr(a);
    for (int i = 0; i < n; i++) pulse(2, base + 8'(i));
    if (do_stop) pulse(1, 8'h00);
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 200 && busy; g++) @(negedge clk);
  endtask

  task automatic read_check(string r, int a, int n);
    set_addr(a);
    pulse(0, 8'h00); pulse(2, DEVR);
    chk({r, " read ack"}, {31'd0, ack}, 32'd1);
    for (int i = 0; i < n; i++) begin
      repeat (2) @(negedge clk);
      chk(r, {24'd0, rd_data}, {24'd0, mmem[(a + i) % MEMN]});
      pulse(3, 8'h00);
    end
    pulse(1, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog (%s): actual=running expected=finished", req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    req = "R9";
    chk("R9 ack in reset", {31'd0, ack}, 32'd0);
    chk("R9 busy in reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 ack after reset", {31'd0, ack}, 32'd0);
    live = 1;

    // R1 device address match and mismatch
    req = "R1";
    pulse(0, 8'h00); pulse(2, DEVW);
    chk("R1 match ack", {31'd0, ack}, 32'd1);
    pulse(0, 8'h00); pulse(2, 8'hA2);
    chk("R1 wrong select", {31'd0, ack}, 32'd0);
    pulse(2, 8'h00);
    chk("R1 ignored after mismatch", {31'd0, ack}, 32'd0);
    pulse(0, 8'h00); pulse(2, 8'hBA);
    chk("R1 wrong type", {31'd0, ack}, 32'd0);
    pulse(1, 8'h00);

    // R2 / R4 write, busy length
    req = "R2";
    set_addr(16'h010A);
    chk("R2 address bytes ack", {31'd0, ack}, 32'd1);
    req = "R4";
    for (int i = 0; i < 3; i++) pulse(2, 8'h11 * 8'(i + 1));
    pulse(1, 8'h00);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk("R4 busy length", n, TW);
    read_check("R4", 16'h010A, 3);

    // R5 polling during busy
    req = "R5";
    write_seq(16'h0080, 2, 8'h40, 1);
    pulse(0, 8'h00); pulse(2, DEVW);
    chk("R5 no ack while busy", {31'd0, ack}, 32'd0);
    wait_idle();
    pulse(0, 8'h00); pulse(2, DEVW);
    chk("R5 ack after cycle", {31'd0, ack}, 32'd1);
    pulse(0, 8'h00);
    chk("R10 start clears ack", {31'd0, ack}, 32'd0);
    pulse(1, 8'h00);

    // R6 stop without data
    req = "R6";
    set_addr(16'h0040);
    pulse(1, 8'h00);
    repeat (3) @(negedge clk);
    chk("R6 no busy", {31'd0, busy}, 32'd0);

    // R3 page wrap
    req = "R3";
    write_seq(16'h001E, 10, 8'hB0, 1);
    wait_idle();
    read_check("R3", 16'h0018, 8);

    // R7 write protect
    req = "R7";
    write_seq(16'h0040, 1, 8'h99, 1);
    wait_idle();
    wr_protect = 1'b1;
    write_seq(16'h0040, 1, 8'h77, 0);
    chk("R7 data still acked", {31'd0, ack}, 32'd1);
    pulse(1, 8'h00);
    repeat (2) @(negedge clk);
    chk("R7 no busy", {31'd0, busy}, 32'd0);
    wr_protect = 1'b0;
    read_check("R7", 16'h0040, 1);

    // R8 read wrap at end of storage
    req = "R8";
    write_seq(MEMN - 1, 1, 8'h5A, 1);
    wait_idle();
    write_seq(0, 1, 8'hC3, 1);
    wait_idle();
    read_check("R8", MEMN - 1, 2);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule